// File: doc/BRIEF.md
# External Interrupt Pin Detector

This block watches a single asynchronous interrupt pin and latches a pending flag when a qualifying event appears on it. Software picks the active polarity (falling/low or rising/high) and the detection style: edge-only, or edge-plus-level. A small control/status byte holds the pending flag (read-only), a write-one-to-clear acknowledge bit that always reads 0, an interrupt enable, a mode select and a polarity select. The interrupt request to the CPU is the pending flag gated by the enable. With the enable off, software polls the flag instead.

The pin first passes through a two-flop synchroniser. Edges are found by comparing the synchronised sample with the previous one, so they come from the raw transitions and not from the selected polarity. In edge-plus-level mode an event is present on every cycle that the synchronised pin sits at its active level. For that reason an acknowledge cannot clear the flag until the pin has gone inactive. When a new event and an acknowledge fall on the same clock, the event wins.

The pending flag is a two-state machine. State `ST_IDLE` has no request pending. State `ST_PEND` has a request latched. The transitions are:
- `ST_IDLE -> ST_PEND` on any event.
- `ST_PEND -> ST_IDLE` on an acknowledge write in a cycle with no event.
- Every other case holds the current state.

Top module: `ext_irq_detector`

## Requirements
- R1: A pin change that is applied before rising clock edge k is sampled at edge k and reaches the synchronised sample at edge k+1. A resulting event sets the flag at edge k+2, so the flag is not visible after edges k or k+1.
- R2: With mode 0 and polarity 0, a falling edge sets the flag. A rising edge does not set it. A pin held low does not set the flag again after an acknowledge.
- R3: With mode 0 and polarity 1, a rising edge sets the flag and a falling edge does not.
- R4: With mode 1, the active level (low for polarity 0, high for polarity 1) sets the flag on every cycle. An acknowledge leaves the flag set while that level persists. The acknowledge clears the flag once the pin is inactive.
- R5: A register write with bit 1 = 1 clears the flag at that edge. A write with bit 1 = 0 leaves the flag unchanged.
- R6: The register reads as: bit 0 flag, bit 1 always 0, bit 2 enable, bit 3 mode, bit 4 polarity, bits 7:5 always 0. Writes to bit 0 and to bits 7:5 have no effect.
- R7: `irq_o` is 1 exactly when the flag and the enable bit are both 1.
- R8: An event and an acknowledge in the same cycle leave the flag set.
- R9: After reset the register reads 0x00 (flag clear, falling edge, edge-only, disabled) and `irq_o` is 0.
- R10: Changing the polarity in edge-only mode while the pin is steady does not set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | Asynchronous external interrupt pin |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| irq_o | output | 1 | Interrupt request to the CPU |

## Verification
The detector is driven with the following patterns, each aimed at a different distinction:
- Isolated falling and rising edges under both polarities separate edge sensing from its polarity.
- A pin held at its active level across an acknowledge separates edge-only mode from edge-plus-level mode.
- An acknowledge landing on the same clock as a fresh edge shows that the event takes priority.
- Polarity flips with a steady pin confirm that no edge is created from the control change.
- A long random mix of pin toggles and register writes is compared every cycle against a behavioural model. It exposes any disagreement in synchroniser latency, gating or read-back layout.

// File: rtl/eirq_pkg.sv
package eirq_pkg;

    localparam int REG_W      = 8;
    localparam int FLAG_BIT   = 0;
    localparam int ACK_BIT    = 1;
    localparam int EN_BIT     = 2;
    localparam int MODE_BIT   = 3;
    localparam int POL_BIT    = 4;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_PEND = 1'b1
    } flag_state_e;

    typedef struct packed {
        logic pol;
        logic level_mode;
        logic enable;
    } eirq_ctrl_t;

endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= async_i;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= 1'b0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain[LAST];
endmodule

// File: rtl/eirq_event.sv
module eirq_event (
    input  logic clk,
    input  logic rst_n,
    input  logic sample_i,
    input  logic pol_i,
    input  logic level_mode_i,
    output logic event_o,
    output logic level_hold_o
);
    logic history;
    logic active_now;
    logic edge_seen;

    // history is the raw previous sample, so a polarity change cannot fabricate an edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) history <= 1'b0;
        else        history <= sample_i;
    end

    always_comb begin
        active_now   = pol_i ? sample_i : ~sample_i;
        edge_seen    = pol_i ? (sample_i & ~history) : (~sample_i & history);
        level_hold_o = level_mode_i & active_now;
        event_o      = edge_seen | level_hold_o;
    end
endmodule

// File: rtl/eirq_ctrl_reg.sv
module eirq_ctrl_reg
    import eirq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_i,
    input  logic [REG_W-1:0] wdata_i,
    output eirq_ctrl_t ctrl_o,
    output logic       ack_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_o <= '0;
        end else if (wr_i) begin
            ctrl_o.pol        <= wdata_i[POL_BIT];
            ctrl_o.level_mode <= wdata_i[MODE_BIT];
            ctrl_o.enable     <= wdata_i[EN_BIT];
        end
    end

    assign ack_o = wr_i & wdata_i[ACK_BIT];
endmodule

// File: rtl/eirq_flag_fsm.sv
module eirq_flag_fsm
    import eirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic event_i,
    input  logic level_hold_i,
    input  logic ack_i,
    input  logic enable_i,
    output logic pending_o,
    output logic irq_o
);
    flag_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (event_i) state_nx = ST_PEND;
            ST_PEND: if (ack_i && !event_i) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        pending_o = 1'b0;
        unique case (state)
            ST_IDLE: pending_o = 1'b0;
            ST_PEND: pending_o = 1'b1;
            default: pending_o = 1'b0;
        endcase
        irq_o = pending_o & enable_i;
    end

    // R8
    event_beats_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (event_i && ack_i) |=> pending_o);

    // R5
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_o && ack_i && !event_i) |=> !pending_o);

    // R4
    level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level_hold_i |=> pending_o);

    // R2
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pending_o && !event_i) |=> !pending_o);

    // R5
    flag_only_by_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_o && !ack_i) |=> pending_o);
endmodule

// File: rtl/ext_irq_detector.sv
module ext_irq_detector
    import eirq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_i,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq_o
);
    eirq_ctrl_t ctrl;
    logic       ack;
    logic       pin_sync;
    logic       evt;
    logic       level_hold;
    logic       pending;
    logic       unused_wbits;

    assign unused_wbits = ^{reg_wdata[7:5], reg_wdata[FLAG_BIT]};

    eirq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_i),
        .sync_o  (pin_sync)
    );

    eirq_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (reg_wr),
        .wdata_i (reg_wdata),
        .ctrl_o  (ctrl),
        .ack_o   (ack)
    );

    eirq_event u_event (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_i     (pin_sync),
        .pol_i        (ctrl.pol),
        .level_mode_i (ctrl.level_mode),
        .event_o      (evt),
        .level_hold_o (level_hold)
    );

    eirq_flag_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .event_i      (evt),
        .level_hold_i (level_hold),
        .ack_i        (ack),
        .enable_i     (ctrl.enable),
        .pending_o    (pending),
        .irq_o        (irq_o)
    );

    always_comb begin
        reg_rdata           = '0;
        reg_rdata[FLAG_BIT] = pending;
        reg_rdata[EN_BIT]   = ctrl.enable;
        reg_rdata[MODE_BIT] = ctrl.level_mode;
        reg_rdata[POL_BIT]  = ctrl.pol;
    end

    // R7
    irq_disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[EN_BIT] |-> !irq_o);

    // R6
    ack_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[ACK_BIT] == 1'b0);
endmodule

// File: tb/ext_irq_detector_test.sv
module ext_irq_detector_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin_i = 1'b1;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq_o;

    int checks = 0;
    int errors = 0;

    // behavioural model state
    bit m_s1, m_s2, m_prev, m_flag, m_en, m_mode, m_pol;

    ext_irq_detector uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_i     (pin_i),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_o     (irq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        bit lvl, lvl_prev, ev, ack;
        if (!rst_n) begin
            {m_s1, m_s2, m_prev, m_flag, m_en, m_mode, m_pol} = '0;
        end else begin
            lvl      = m_pol ? m_s2 : !m_s2;
            lvl_prev = m_pol ? m_prev : !m_prev;
            ev       = (lvl && !lvl_prev) || (m_mode && lvl);
            ack      = reg_wr && reg_wdata[1];
            if (ev)       m_flag = 1'b1;
            else if (ack) m_flag = 1'b0;
            m_prev = m_s2;
            m_s2   = m_s1;
            m_s1   = pin_i;
            if (reg_wr) begin
                m_en   = reg_wdata[2];
                m_mode = reg_wdata[3];
                m_pol  = reg_wdata[4];
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (reg_rdata[0] !== m_flag) begin
                errors++;
                $display("FAIL R1 flag timing: actual %0b expected %0b", reg_rdata[0], m_flag);
            end
            checks++;
            if (irq_o !== (m_flag && m_en)) begin
                errors++;
                $display("FAIL R7 irq: actual %0b expected %0b", irq_o, m_flag && m_en);
            end
            checks++;
            if (reg_rdata !== {3'b000, m_pol, m_mode, m_en, 1'b0, m_flag}) begin
                errors++;
                $display("FAIL R6 readback: actual %02h expected %02h", reg_rdata,
                         {3'b000, m_pol, m_mode, m_en, 1'b0, m_flag});
            end
        end
    end

    task automatic check(input logic [7:0] actual, input logic [7:0] expected, input string tag);
        checks++;
        if (actual !== expected) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, actual, expected);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d);
        reg_wr = 1'b1;
        reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        reg_wdata = 8'h00;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(3);
        check(reg_rdata, 8'h00, "R9 reset rdata");
        check({7'b0, irq_o}, 8'h00, "R9 reset irq");

        wr(8'h04);
        pin_i = 1'b0;
        wait_cyc(2);
        check({7'b0, reg_rdata[0]}, 8'h00, "R1 flag not yet");
        wait_cyc(1);
        check(reg_rdata, 8'h05, "R1 flag after sync");
        check({7'b0, irq_o}, 8'h01, "R7 irq enabled");

        wr(8'h06);
        check({7'b0, reg_rdata[0]}, 8'h00, "R5 ack clears");
        wait_cyc(3);
        check({7'b0, reg_rdata[0]}, 8'h00, "R2 steady low no retrigger");
        pin_i = 1'b1;
        wait_cyc(4);
        check({7'b0, reg_rdata[0]}, 8'h00, "R2 rising ignored");
        pin_i = 1'b0;
        wait_cyc(3);
        check({7'b0, reg_rdata[0]}, 8'h01, "R2 falling sets");
        wr(8'h04);
        check({7'b0, reg_rdata[0]}, 8'h01, "R5 zero ack no effect");
        wr(8'h06);
        check({7'b0, reg_rdata[0]}, 8'h00, "R5 ack clears again");

        wr(8'h14);
        wait_cyc(4);
        check({7'b0, reg_rdata[0]}, 8'h00, "R10 polarity flip quiet");
        pin_i = 1'b1;
        wait_cyc(3);
        check({7'b0, reg_rdata[0]}, 8'h01, "R3 rising sets");
        wr(8'h16);
        pin_i = 1'b0;
        wait_cyc(4);
        check({7'b0, reg_rdata[0]}, 8'h00, "R3 falling ignored");
        wr(8'h04);
        wait_cyc(4);
        check({7'b0, reg_rdata[0]}, 8'h00, "R10 polarity flip back quiet");

        wr(8'h0C);
        wait_cyc(1);
        check({7'b0, reg_rdata[0]}, 8'h01, "R4 low level sets");
        wr(8'h0E);
        check({7'b0, reg_rdata[0]}, 8'h01, "R4 ack blocked by level");
        pin_i = 1'b1;
        wait_cyc(2);
        check({7'b0, reg_rdata[0]}, 8'h01, "R4 flag held after release");
        wr(8'h0E);
        check({7'b0, reg_rdata[0]}, 8'h00, "R4 ack after release");

        wr(8'h04);
        pin_i = 1'b0;
        wait_cyc(2);
        wr(8'h06);
        check({7'b0, reg_rdata[0]}, 8'h01, "R8 event beats ack");
        wr(8'h06);
        check({7'b0, reg_rdata[0]}, 8'h00, "R8 later ack clears");

        wr(8'hE3);
        check(reg_rdata, 8'h00, "R6 reserved and flag bits ignored");
        wr(8'h1E);
        check(reg_rdata, 8'h1C, "R6 layout and ack reads zero");

        wr(8'h00);
        pin_i = 1'b1;
        wait_cyc(3);
        pin_i = 1'b0;
        wait_cyc(3);
        check(reg_rdata, 8'h01, "R7 flag set while disabled");
        check({7'b0, irq_o}, 8'h00, "R7 no irq while disabled");
        wr(8'h04);
        check({7'b0, irq_o}, 8'h01, "R7 irq on enable");
        wr(8'h06);

        for (int i = 0; i < 2000; i++) begin
            if ($urandom_range(0, 3) == 0) pin_i = ~pin_i;
            if ($urandom_range(0, 5) == 0) wr(8'($urandom));
            else wait_cyc(1);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule